// File: doc/BRIEF.md
# Packed Narrowing Pack and Interleaving Unpack Unit

This block rearranges the lanes of two 64-bit operands, called the destination and the source, into one 64-bit result. It covers two kinds of work. Narrowing packs clamp each wide lane of both operands into a lane half as wide and place the results together in one word. Interleaving unpacks take either the low halves or the high halves of the two operands and interleave their elements.

An operation is presented with `in_valid`, an opcode and the two operands. The lane logic is purely combinational. The result is captured in a register, so it appears with `out_valid` one clock later. A new operation may be presented on every cycle. The block has no arithmetic, no shifts and no sign- or zero-extending widening.

Top module: `lane_shuffle_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `out_valid` is 0 and `result` is all zeros.
- R2: An operation accepted with `in_valid` high at a rising edge drives `out_valid` high and its `result` after that edge. A cycle with `in_valid` low drives `out_valid` low on the next edge, and `result` keeps its last value.
- R3: The `op` encoding is as follows. 0 is the signed pack from 32 to 16 bits. 1 is the signed pack from 16 to 8 bits. 2 is the unsigned pack from 16 to 8 bits. 3, 4 and 5 are the low unpacks at 8, 16 and 32 bits. 6, 7 and 8 are the high unpacks at 8, 16 and 32 bits.
- R4: In the signed pack from 32 to 16 (op 0), each 32-bit lane is read as signed and clamped to -32768..32767. The two destination lanes fill result bits 31:0 and the two source lanes fill bits 63:32.
- R5: In the signed pack from 16 to 8 (op 1), each 16-bit lane is read as signed and clamped to -128..127. The four destination lanes fill result bits 31:0 and the four source lanes fill bits 63:32.
- R6: In the unsigned pack (op 2), each 16-bit lane is read as signed. A negative lane gives 0x00, a lane above 255 gives 0xFF, and any other lane gives its low byte. The lanes are placed as in R5.
- R7: A low unpack of element width E (ops 3, 4, 5 for E = 8, 16, 32) uses elements k = 0 .. 32/E-1. Result element 2k is destination element k, and result element 2k+1 is source element k.
- R8: A high unpack of element width E (ops 6, 7, 8) is built the same way from elements k + 32/E of both operands.
- R9: Opcodes 9 to 15 give an all-zero result, and `out_valid` still rises.
- R10: In every pack and unpack, the lanes of each operand keep their order from least to most significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation select (see R3) |
| dst_a | input | 64 | Destination operand |
| src_b | input | 64 | Source operand |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Registered result word |

## Verification
The bench drives each saturation boundary on both sides: 32767 and 32768, -32768 and -32769, 127 and 128, -128 and -129, and 255, 256 and negative lanes for the unsigned pack. A clamp with an off-by-one limit, or one that reads the input as unsigned, produces a wrong byte in a known position. Operands whose bytes are all distinct show swapped operand halves, reversed lane order, or a low/high mix-up as a misplaced byte in the expected word. Idle cycles and unused opcodes show up when a design drops the held value or passes stale data through.

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit #(
  parameter int OPW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op,
  input  logic [63:0]     dst_a,
  input  logic [63:0]     src_b,
  output logic            out_valid,
  output logic [63:0]     result
);
  localparam int HALF = 32;

  function automatic logic [15:0] clamp_s16(input logic [31:0] v);
    if ($signed(v) > 32'sd32767)       return 16'h7FFF;
    else if ($signed(v) < -32'sd32768) return 16'h8000;
    else                               return v[15:0];
  endfunction

  function automatic logic [7:0] clamp_s8(input logic [15:0] v);
    if ($signed(v) > 16'sd127)       return 8'h7F;
    else if ($signed(v) < -16'sd128) return 8'h80;
    else                             return v[7:0];
  endfunction

  function automatic logic [7:0] clamp_u8(input logic [15:0] v);
    if (v[15])            return 8'h00;
    else if (v > 16'd255) return 8'hFF;
    else                  return v[7:0];
  endfunction

  logic [127:0] both;
  assign both = {src_b, dst_a};

  logic [63:0] pk32, pk16s, pk16u;
  logic [63:0] lo8, lo16, lo32, hi8, hi16, hi32;

  for (genvar i = 0; i < 4; i++) begin : g_pk32
    assign pk32[16*i +: 16] = clamp_s16(both[32*i +: 32]);
  end

  for (genvar i = 0; i < 8; i++) begin : g_pk16
    assign pk16s[8*i +: 8] = clamp_s8(both[16*i +: 16]);
    assign pk16u[8*i +: 8] = clamp_u8(both[16*i +: 16]);
  end

  for (genvar k = 0; k < 4; k++) begin : g_un8
    assign lo8[16*k +: 16] = {src_b[8*k +: 8], dst_a[8*k +: 8]};
    assign hi8[16*k +: 16] = {src_b[HALF+8*k +: 8], dst_a[HALF+8*k +: 8]};
  end

  for (genvar k = 0; k < 2; k++) begin : g_un16
    assign lo16[32*k +: 32] = {src_b[16*k +: 16], dst_a[16*k +: 16]};
    assign hi16[32*k +: 32] = {src_b[HALF+16*k +: 16], dst_a[HALF+16*k +: 16]};
  end

  assign lo32 = {src_b[HALF-1:0], dst_a[HALF-1:0]};
  assign hi32 = {src_b[63:HALF], dst_a[63:HALF]};

  logic [63:0] nxt;
  always_comb begin
    case (op)
      4'd0:    nxt = pk32;
      4'd1:    nxt = pk16s;
      4'd2:    nxt = pk16u;
      4'd3:    nxt = lo8;
      4'd4:    nxt = lo16;
      4'd5:    nxt = lo32;
      4'd6:    nxt = hi8;
      4'd7:    nxt = hi16;
      4'd8:    nxt = hi32;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module lane_shuffle_unit_chk #(
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [OPW-1:0] op,
  input logic [63:0]    dst_a,
  input logic [63:0]    src_b,
  input logic           out_valid,
  input logic [63:0]    result
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_lo32_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd5) |=> result == {$past(src_b[31:0]), $past(dst_a[31:0])});
  p_hi32_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd8) |=> result == {$past(src_b[63:32]), $past(dst_a[63:32])});
  p_neg_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2 && dst_a[15]) |=> result[7:0] == 8'h00);
  p_pos_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd0 && !dst_a[31] && dst_a[30:15] != 16'h0) |=> result[15:0] == 16'h7FFF);
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 4'd8) |=> result == 64'h0);
endmodule

bind lane_shuffle_unit lane_shuffle_unit_chk #(.OPW(OPW)) u_chk (.*);

// File: tb/lane_shuffle_unit_tb.sv
`timescale 1ns/1ps
module lane_shuffle_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [63:0] dst_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lane_shuffle_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .dst_a(dst_a), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int n;
    case (o)
      4'd0: for (int i = 0; i < 2; i++) begin
              r[16*i +: 16]     = sat16(a[32*i +: 32]);
              r[32+16*i +: 16]  = sat16(b[32*i +: 32]);
            end
      4'd1, 4'd2: for (int i = 0; i < 4; i++) begin
              r[8*i +: 8]    = (o == 4'd1) ? sat8s(a[16*i +: 16]) : sat8u(a[16*i +: 16]);
              r[32+8*i +: 8] = (o == 4'd1) ? sat8s(b[16*i +: 16]) : sat8u(b[16*i +: 16]);
            end
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: begin
              n = (o == 4'd3 || o == 4'd6) ? 8 : (o == 4'd4 || o == 4'd7) ? 16 : 32;
              for (int k = 0; k < 32 / n; k++) begin
                int base = (o >= 4'd6) ? 32 : 0;
                for (int bt = 0; bt < n; bt++) begin
                  r[2*n*k + bt]     = a[base + n*k + bt];
                  r[2*n*k + n + bt] = b[base + n*k + bt];
                end
              end
            end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] sat16(input logic [31:0] v);
    int s = $signed(v);
    if (s > 32767) return 16'h7FFF;
    if (s < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [7:0] sat8s(input logic [15:0] v);
    int s = $signed(v);
    if (s > 127) return 8'h7F;
    if (s < -128) return 8'h80;
    return v[7:0];
  endfunction

  function automatic logic [7:0] sat8u(input logic [15:0] v);
    int s = $signed(v);
    if (s < 0) return 8'h00;
    if (s > 255) return 8'hFF;
    return v[7:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] o, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op = o; dst_a = a; src_b = b;
    @(negedge clk);
    check({tag, " valid"}, {63'h0, out_valid}, 64'h1);
    check(tag, result, exp);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'h0, out_valid}, 64'h0);
    check("R1 result in reset", result, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", {63'h0, out_valid}, 64'h0);
    check("R1 result after release", result, 64'h0);
  endtask

  task automatic t_pack32();
    run_op("R4 R10 pack32 bounds", 4'd0, 64'h00010000_FFFF7FFF, 64'h00007FFF_80000000, 64'h7FFF_8000_7FFF_8000);
    run_op("R4 pack32 in range", 4'd0, 64'hFFFF8000_00001234, 64'h00000001_FFFFFFFF, 64'h0001_FFFF_8000_1234);
  endtask

  task automatic t_pack16s();
    run_op("R5 R10 pack16 signed", 4'd1, 64'hFF80_007F_FF7F_0080, 64'h8000_0000_FFFF_1234, 64'h8000FF7F_807F807F);
  endtask

  task automatic t_pack16u();
    run_op("R6 R10 pack16 unsigned", 4'd2, 64'h0080_0100_00FF_8000, 64'h0001_7FFF_0000_FFFF, 64'h01FF0000_80FFFF00);
  endtask

  task automatic t_unpack_lo();
    logic [63:0] a = 64'h88776655_44332211;
    logic [63:0] b = 64'hF0E0D0C0_B0A09080;
    run_op("R7 R3 unpack low 8", 4'd3, a, b, 64'hB044A033_90228011);
    run_op("R7 unpack low 16", 4'd4, a, b, 64'hB0A04433_90802211);
    run_op("R7 unpack low 32", 4'd5, a, b, 64'hB0A09080_44332211);
  endtask

  task automatic t_unpack_hi();
    logic [63:0] a = 64'h88776655_44332211;
    logic [63:0] b = 64'hF0E0D0C0_B0A09080;
    run_op("R8 unpack high 8", 4'd6, a, b, 64'hF088E077_D066C055);
    run_op("R8 unpack high 16", 4'd7, a, b, 64'hF0E08877_D0C06655);
    run_op("R8 unpack high 32", 4'd8, a, b, 64'hF0E0D0C0_88776655);
  endtask

  task automatic t_unused();
    run_op("R9 unused op 9", 4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0);
    run_op("R9 unused op 15", 4'd15, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'h0);
  endtask

  task automatic t_hold();
    logic [63:0] kept;
    run_op("R2 load", 4'd5, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 64'h33334444_CCCCDDDD);
    kept = result;
    @(negedge clk);
    in_valid = 1'b0; op = 4'd3; dst_a = '1; src_b = '1;
    @(negedge clk);
    check("R2 out_valid low when idle", {63'h0, out_valid}, 64'h0);
    check("R2 result held when idle", result, kept);
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 60; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [3:0]  o = 4'(n % 10);
      run_op("R3 R10 sweep", o, a, b, model(o, a, b));
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    in_valid = 1'b1; op = 4'd5; dst_a = 64'h1; src_b = 64'h2;
    @(negedge clk);
    check("R2 first of pair", result, 64'h00000002_00000001);
    op = 4'd8; dst_a = 64'h3_00000000; src_b = 64'h4_00000000;
    @(negedge clk);
    check("R2 second of pair", result, 64'h00000004_00000003);
    check("R2 valid stays high", {63'h0, out_valid}, 64'h1);
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd17));
    t_reset();
    t_pack32();
    t_pack16s();
    t_pack16u();
    t_unpack_lo();
    t_unpack_hi();
    t_unused();
    t_hold();
    t_back_to_back();
    t_sweep();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule